// File: doc/BRIEF.md
# Four-Segment Floating-Point Add/Subtract Pipeline

This block adds or subtracts two floating-point operands in four registered segments. Each operand has a sign bit, an 8-bit two's-complement exponent and a 16-bit fraction mantissa. Its value is (-1)^sign × (mantissa / 2^16) × 2^exponent. A normalized mantissa has bit 15 set, and a mantissa of zero stands for the value zero.

The first segment finds the exponent difference and picks the larger exponent. The second shifts the smaller operand's mantissa right to line it up. The third adds or subtracts the magnitudes. The fourth normalizes the result in whichever direction it needs.

A new operand pair may be offered on every clock, and nothing stalls. Each result appears exactly four cycles after its inputs were sampled, marked by a valid flag. Rounding, special values and exception flags are not provided, and an exponent that leaves the 8-bit range wraps.

Top module: `fpa_add_pipe`

## Requirements
- R1: A pair sampled with `in_valid`=1 at a rising edge gives `out_valid`=1 after the fourth rising edge that follows. A pair sampled with `in_valid`=0 gives `out_valid`=0 there. Pairs are accepted on consecutive cycles without loss.
- R2: While `rst_n` is low and until the first pair arrives, `out_valid`, `out_sign`, `out_exp` and `out_man` are 0.
- R3: For operands of equal effective sign, the result exponent is the larger input exponent. The mantissa of the other operand is shifted right by the exponent difference before the add, and bits shifted out are discarded (truncated).
- R4: If the magnitude sum reaches 2^16 or more, the result mantissa is the sum shifted right by one with its low bit dropped, and the exponent is the larger exponent plus one.
- R5: `in_op`=0 selects a+b and `in_op`=1 selects a-b. Subtraction behaves as addition with b's sign inverted.
- R6: When the signed result is negative, `out_man` holds its magnitude and `out_sign`=1. Otherwise `out_sign`=0.
- R7: A nonzero result whose bit 15 is clear is shifted left until bit 15 is 1, and the exponent is decreased by the number of places shifted (up to 15).
- R8: A zero result gives `out_man`=0, `out_exp`=0 and `out_sign`=0.
- R9: When the exponent difference is 16 or more, the smaller operand contributes nothing. The result is the larger operand with its effective sign.
- R10: Exponents are compared as signed two's-complement values, so 8'hFD (-3) is smaller than 8'h02 (+2). When the exponents are equal, the alignment shift is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_op | input | 1 | 0 = add, 1 = subtract (a - b) |
| a_sign | input | 1 | Sign of operand a, 1 = negative |
| a_exp | input | 8 | Two's-complement exponent of a |
| a_man | input | 16 | Fraction mantissa of a |
| b_sign | input | 1 | Sign of operand b, 1 = negative |
| b_exp | input | 8 | Two's-complement exponent of b |
| b_man | input | 16 | Fraction mantissa of b |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | 8 | Two's-complement exponent of the result |
| out_man | output | 16 | Normalized mantissa of the result |

## Verification
The bench targets these corner cases:
- A carry out of the fraction range. A design that ignored it would lose the top bit instead of shifting right and bumping the exponent.
- Subtractions whose result is negative or nearly cancels. These expose a wrong sign, or a normalization that stops short of bit 15 or adjusts the exponent by the wrong amount.
- Exact cancellation. A careless design leaves a stale exponent or a negative zero here.
- Negative exponents and differences of 16 and more. These catch an unsigned compare that picks the wrong operand, or a shifter that wraps its shift amount.
- Back-to-back and gapped streams. These show whether the valid flag drifts from its four-cycle position.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int FPA_EW = 8;
    localparam int FPA_MW = 16;
    localparam int FPA_GW = FPA_MW + 1;
    localparam int FPA_SW = FPA_EW + 1;

    typedef struct packed {
        logic              vld;
        logic              big_s;
        logic              small_s;
        logic [FPA_EW-1:0] exp;
        logic [FPA_MW-1:0] big_m;
        logic [FPA_MW-1:0] small_m;
        logic [FPA_SW-1:0] shamt;
    } seg1_t;

    typedef struct packed {
        logic              vld;
        logic              big_s;
        logic              small_s;
        logic [FPA_EW-1:0] exp;
        logic [FPA_MW-1:0] big_m;
        logic [FPA_MW-1:0] small_m;
    } seg2_t;

    typedef struct packed {
        logic              vld;
        logic              sign;
        logic [FPA_EW-1:0] exp;
        logic [FPA_GW-1:0] mag;
    } seg3_t;

    typedef struct packed {
        logic              vld;
        logic              sign;
        logic [FPA_EW-1:0] exp;
        logic [FPA_MW-1:0] man;
    } seg4_t;

    typedef struct packed {
        seg1_t s1;
        seg2_t s2;
        seg3_t s3;
        seg4_t s4;
    } pipe_t;
endpackage

// File: rtl/fpa_seg_cmp.sv
module fpa_seg_cmp
    import fpa_pkg::*;
(
    input  logic              vld,
    input  logic              op,
    input  logic              a_s,
    input  logic [FPA_EW-1:0] a_e,
    input  logic [FPA_MW-1:0] a_m,
    input  logic              b_s,
    input  logic [FPA_EW-1:0] b_e,
    input  logic [FPA_MW-1:0] b_m,
    output seg1_t             seg
);
    logic [FPA_SW-1:0] dif;
    logic              a_big;
    logic              b_eff;

    always_comb begin
        dif   = {a_e[FPA_EW-1], a_e} - {b_e[FPA_EW-1], b_e};
        a_big = ~dif[FPA_SW-1];
        b_eff = b_s ^ op;
        seg.vld     = vld;
        seg.big_s   = a_big ? a_s : b_eff;
        seg.small_s = a_big ? b_eff : a_s;
        seg.exp     = a_big ? a_e : b_e;
        seg.big_m   = a_big ? a_m : b_m;
        seg.small_m = a_big ? b_m : a_m;
        seg.shamt   = a_big ? dif : (~dif + 1'b1);
    end
endmodule

// File: rtl/fpa_seg_addsub.sv
module fpa_seg_addsub
    import fpa_pkg::*;
(
    input  seg2_t seg_in,
    output seg3_t seg_out
);
    logic [FPA_GW-1:0] big_x;
    logic [FPA_GW-1:0] small_x;

    always_comb begin
        big_x   = {1'b0, seg_in.big_m};
        small_x = {1'b0, seg_in.small_m};
        seg_out.vld = seg_in.vld;
        seg_out.exp = seg_in.exp;
        if (seg_in.big_s == seg_in.small_s) begin
            seg_out.mag  = big_x + small_x;
            seg_out.sign = seg_in.big_s;
        end else if (big_x >= small_x) begin
            seg_out.mag  = big_x - small_x;
            seg_out.sign = seg_in.big_s;
        end else begin
            seg_out.mag  = small_x - big_x;
            seg_out.sign = ~seg_in.big_s;
        end
    end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpa_seg_norm.sv
module fpa_seg_norm
    import fpa_pkg::*;
(
    input  seg3_t seg_in,
    output seg4_t seg_out
);
    localparam int CW = $clog2(FPA_MW + 1);

    logic [CW-1:0] lz;

    fpa_lzc #(.W(FPA_MW), .CW(CW)) u_lzc (
        .vec (seg_in.mag[FPA_MW-1:0]),
        .cnt (lz)
    );

    always_comb begin
        seg_out.vld = seg_in.vld;
        if (seg_in.mag[FPA_GW-1]) begin
            seg_out.sign = seg_in.sign;
            seg_out.man  = seg_in.mag[FPA_GW-1:1];
            seg_out.exp  = seg_in.exp + 1'b1;
        end else if (seg_in.mag == '0) begin
            seg_out.sign = 1'b0;
            seg_out.man  = '0;
            seg_out.exp  = '0;
        end else begin
            seg_out.sign = seg_in.sign;
            seg_out.man  = seg_in.mag[FPA_MW-1:0] << lz;
            seg_out.exp  = seg_in.exp - FPA_EW'(lz);
        end
    end
endmodule

// File: rtl/fpa_add_pipe.sv
module fpa_add_pipe
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              a_sign,
    input  logic [FPA_EW-1:0] a_exp,
    input  logic [FPA_MW-1:0] a_man,
    input  logic              b_sign,
    input  logic [FPA_EW-1:0] b_exp,
    input  logic [FPA_MW-1:0] b_man,
    output logic              out_valid,
    output logic              out_sign,
    output logic [FPA_EW-1:0] out_exp,
    output logic [FPA_MW-1:0] out_man
);
    pipe_t pipe_d, pipe_q;
    seg1_t cmp_seg;
    seg3_t sum_seg;
    seg4_t norm_seg;

    fpa_seg_cmp u_cmp (
        .vld (in_valid),
        .op  (in_op),
        .a_s (a_sign),
        .a_e (a_exp),
        .a_m (a_man),
        .b_s (b_sign),
        .b_e (b_exp),
        .b_m (b_man),
        .seg (cmp_seg)
    );

    fpa_seg_addsub u_addsub (
        .seg_in  (pipe_q.s2),
        .seg_out (sum_seg)
    );

    fpa_seg_norm u_norm (
        .seg_in  (pipe_q.s3),
        .seg_out (norm_seg)
    );

    always_comb begin
        pipe_d            = pipe_q;
        pipe_d.s1         = cmp_seg;
        pipe_d.s2.vld     = pipe_q.s1.vld;
        pipe_d.s2.big_s   = pipe_q.s1.big_s;
        pipe_d.s2.small_s = pipe_q.s1.small_s;
        pipe_d.s2.exp     = pipe_q.s1.exp;
        pipe_d.s2.big_m   = pipe_q.s1.big_m;
        if (pipe_q.s1.shamt >= FPA_SW'(FPA_MW))
            pipe_d.s2.small_m = '0;
        else
            pipe_d.s2.small_m = pipe_q.s1.small_m >> pipe_q.s1.shamt;
        pipe_d.s3         = sum_seg;
        pipe_d.s4         = norm_seg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s4.vld;
    assign out_sign  = pipe_q.s4.sign;
    assign out_exp   = pipe_q.s4.exp;
    assign out_man   = pipe_q.s4.man;
endmodule

// File: rtl/fpa_add_pipe_chk.sv
module fpa_add_pipe_chk
    import fpa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_op,
    input logic              a_sign,
    input logic [FPA_EW-1:0] a_exp,
    input logic [FPA_MW-1:0] a_man,
    input logic              b_sign,
    input logic [FPA_EW-1:0] b_exp,
    input logic [FPA_MW-1:0] b_man,
    input logic              out_valid,
    input logic              out_sign,
    input logic [FPA_EW-1:0] out_exp,
    input logic [FPA_MW-1:0] out_man
);
    logic [2:0] since_rst;
    logic       self_cancel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 4) since_rst <= since_rst + 1'b1;
    end

    assign self_cancel = in_valid && in_op && (a_sign == b_sign) &&
                         (a_exp == b_exp) && (a_man == b_man);

    AST_LATENCY_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R1

    AST_OUT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_man != '0) |-> out_man[FPA_MW-1]); // R7

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_man == '0) |-> (out_exp == '0 && !out_sign)); // R8

    AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4 && $past(self_cancel, 4)) |->
        (out_valid && out_man == '0 && out_exp == '0 && !out_sign)); // R8
endmodule

bind fpa_add_pipe fpa_add_pipe_chk u_chk (.*);

// File: tb/fpa_add_pipe_tb.sv
module fpa_add_pipe_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_op = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [7:0]  a_exp = '0, b_exp = '0;
    logic [15:0] a_man = '0, b_man = '0;
    logic        out_valid, out_sign;
    logic [7:0]  out_exp;
    logic [15:0] out_man;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit          v;
        bit          s;
        logic [7:0]  e;
        logic [15:0] m;
        string       tag;
    } exp_t;

    exp_t pend[$];

    always #4 clk = ~clk;

    fpa_add_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_man(out_man)
    );

    function automatic exp_t model(bit op, bit sa, logic [7:0] ea, logic [15:0] ma,
                                   bit sb, logic [7:0] eb, logic [15:0] mb);
        exp_t r;
        int xa = int'($signed(ea));
        int xb = int'($signed(eb));
        int va, vb, sum, mag, e, d;
        bit sbe = sb ^ op;
        if (xa >= xb) begin
            d = xa - xb; e = xa;
            va = sa ? -int'(ma) : int'(ma);
            vb = (d >= 16) ? 0 : (int'(mb) >> d);
            if (sbe) vb = -vb;
        end else begin
            d = xb - xa; e = xb;
            vb = sbe ? -int'(mb) : int'(mb);
            va = (d >= 16) ? 0 : (int'(ma) >> d);
            if (sa) va = -va;
        end
        sum = va + vb;
        r.v = 1; r.tag = "";
        if (sum == 0) begin
            r.s = 0; r.e = 8'h00; r.m = 16'h0000;
            return r;
        end
        r.s = (sum < 0);
        mag = (sum < 0) ? -sum : sum;
        while (mag >= 65536) begin mag = mag >> 1; e = e + 1; end
        while (mag < 32768)  begin mag = mag << 1; e = e - 1; end
        r.e = 8'(e);
        r.m = 16'(mag);
        return r;
    endfunction

    task automatic check_out();
        exp_t x;
        total++;
        if (pend.size() < 4) begin
            if (out_valid !== 1'b0 || out_sign !== 1'b0 || out_exp !== 8'h00 || out_man !== 16'h0000) begin
                bad++;
                $display("FAIL R2 idle out v=%0b s=%0b e=%02h m=%04h exp v=0 s=0 e=00 m=0000",
                         out_valid, out_sign, out_exp, out_man);
            end
            return;
        end
        x = pend.pop_front();
        if (!x.v) begin
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R1 gap out_valid=%0b exp=0", out_valid);
            end
        end else if (out_valid !== 1'b1 || out_sign !== x.s || out_exp !== x.e || out_man !== x.m) begin
            bad++;
            $display("FAIL %s out v=%0b s=%0b e=%02h m=%04h exp v=1 s=%0b e=%02h m=%04h",
                     x.tag, out_valid, out_sign, out_exp, out_man, x.s, x.e, x.m);
        end
    endtask

    task automatic issue(bit v, bit op, bit sa, logic [7:0] ea, logic [15:0] ma,
                         bit sb, logic [7:0] eb, logic [15:0] mb, string tag);
        exp_t x;
        @(negedge clk);
        check_out();
        in_valid = v; in_op = op;
        a_sign = sa; a_exp = ea; a_man = ma;
        b_sign = sb; b_exp = eb; b_man = mb;
        if (v) x = model(op, sa, ea, ma, sb, eb, mb);
        else begin x.v = 0; x.s = 0; x.e = '0; x.m = '0; end
        x.tag = tag;
        pend.push_back(x);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0, 8'h00, 16'h0, 0, 8'h00, 16'h0, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_man !== 16'h0 || out_exp !== 8'h0 || out_sign !== 1'b0) begin
            bad++;
            $display("FAIL R2 in reset v=%0b e=%02h m=%04h exp all 0", out_valid, out_exp, out_man);
        end
        rst_n = 1'b1;
        // R3: aligned addition, larger exponent kept
        issue(1, 0, 0, 8'h05, 16'h8000, 0, 8'h02, 16'h8000, "R3");
        // R3: shifted-out bits truncated
        issue(1, 0, 0, 8'h01, 16'h8000, 0, 8'h00, 16'h8003, "R3");
        // R4: carry out of the fraction range
        issue(1, 0, 0, 8'h03, 16'hF000, 0, 8'h02, 16'hD000, "R4");
        issue(1, 0, 0, 8'h00, 16'hFFFF, 0, 8'h00, 16'hFFFF, "R4");
        idle(2);
        // R5: subtract via op bit; R7 one-place left shift
        issue(1, 1, 0, 8'h00, 16'hC000, 0, 8'h00, 16'h8000, "R5");
        issue(1, 1, 0, 8'h00, 16'hC000, 1, 8'h00, 16'h8000, "R5");
        // R6: negative difference
        issue(1, 1, 0, 8'h00, 16'h8000, 0, 8'h00, 16'hC000, "R6");
        issue(1, 0, 1, 8'h02, 16'h9000, 0, 8'h01, 16'h8000, "R6");
        issue(1, 0, 1, 8'h04, 16'h8000, 1, 8'h04, 16'h8000, "R6");
        // R7: deep left normalization
        issue(1, 1, 0, 8'h00, 16'h8001, 0, 8'h00, 16'h8000, "R7");
        issue(1, 1, 0, 8'h07, 16'h8100, 0, 8'h07, 16'h8000, "R7");
        idle(1);
        // R8: exact cancellation
        issue(1, 1, 0, 8'h10, 16'hA5A5, 0, 8'h10, 16'hA5A5, "R8");
        issue(1, 0, 1, 8'hF0, 16'h8123, 0, 8'hF0, 16'h8123, "R8");
        // R9: difference of 16 and more
        issue(1, 0, 0, 8'h14, 16'h9000, 0, 8'h03, 16'hFFFF, "R9");
        issue(1, 1, 0, 8'h10, 16'h9000, 0, 8'h00, 16'hFFFF, "R9");
        issue(1, 0, 0, 8'h80, 16'hFFFF, 1, 8'h7F, 16'h8000, "R9");
        // R10: signed exponent compare
        issue(1, 0, 0, 8'hFD, 16'h8000, 0, 8'h02, 16'h8000, "R10");
        issue(1, 1, 0, 8'h02, 16'h8000, 0, 8'hFD, 16'hC000, "R10");
        issue(1, 0, 0, 8'hFF, 16'hE000, 0, 8'hFF, 16'hC000, "R10");
        idle(3);
        // R1: back-to-back stream with random gaps
        for (int i = 0; i < 400; i++) begin
            bit v = ($urandom % 4) != 0;
            logic [7:0] ea = 8'(int'($urandom % 61) - 30);
            logic [7:0] eb = 8'(int'($urandom % 61) - 30);
            issue(v, 1'($urandom), 1'($urandom), ea, 16'($urandom) | 16'h8000,
                  1'($urandom), eb, 16'($urandom) | 16'h8000, "R1");
        end
        idle(5);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired out=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule